// File: doc/BRIEF.md
# Chip-Select Strobe Sequencer

This block shapes the strobes of one external-memory bus cycle at quarter-clock resolution. A cycle request brings the direction, a region number, a burst flag and that region's timing options: first-access wait states, per-beat burst wait states, a chip-select delay code, relaxed mode, external termination, an idle-after-read option and two options that move the edges of the burst indicator. The block then drives chip select, the read strobe (output enable) or the write strobe (write/byte enable), and the burst indicator. It pulses `done_o` when the cycle is over.

The block runs on the bus clock times four. `qtick` is the quarter enable, and nothing advances on a clock where it is low. Requests are taken only on a tick while the block is idle. All strobes are active high. A burst always has `BEATS` beats (`BEATS` of at least 4), and a single access has one beat. The block keeps the region, direction and idle option of the last access. It uses them to decide whether to insert one idle bus clock before the next access.

Top module: `cs_strobe_seq`

## Requirements
- R1: After reset, `cs_o`, `oe_o`, `we_o`, `burst_o`, `done_o` and `cfg_err_o` are all low.
- R2: With internal termination, the first beat lasts 2 + W1 bus clocks, plus one more clock in relaxed mode. W1 is `opt_wait`, doubled in relaxed mode. Each further burst beat lasts 1 + Wb clocks, where Wb is `opt_bwait`, doubled in relaxed mode. `ta_in` has no effect. `done_o` is high for exactly one clock, right after the cycle's final quarter tick.
- R3: With `opt_ext` = 1, a beat ends only at the last quarter of a bus clock in which `ta_in` is high. The first beat lasts at least 2 clocks, or 3 in relaxed mode. Later beats last at least 1 clock.
- R4: `cs_o` rises a number of quarters after cycle start set by `opt_csd`: 0 for code 00, 1 for code 10, 2 for code 11. In relaxed mode, codes 10 and 11 add 4 quarters. `cs_o` then stays high until the cycle ends.
- R5: `oe_o` (read) or `we_o` (write) rises 3 quarters after cycle start, or 7 in relaxed mode, and stays high until the cycle ends. The strobe of the other direction stays low.
- R6: During a burst, `burst_o` is high from beat 0 through beat BEATS-2, counting beats from 0. `opt_bi_late` moves its rise to the start of beat 1. `opt_bi_trim` moves its fall to the end of beat BEATS-3. Both options are ignored under external termination. `burst_o` stays low for a single access.
- R7: One idle bus clock (4 quarter ticks, all strobes low) is inserted before an access when the previous access was a read with `opt_hold` = 1 and the new access is either a write or a read to a different region.
- R8: `opt_csd` = 01 makes the block act as code 00. Setting both burst-indicator options makes it act as if neither were set. Either case sets `cfg_err_o`, which stays high until reset.
- R9: On a clock with `qtick` low, the cycle's timing does not advance and `cs_o`, `oe_o`, `we_o` and `burst_o` hold their values.
- R10: A request presented while a cycle or an idle gap is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at four times the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| qtick | input | 1 | Quarter-phase enable |
| req_valid | input | 1 | Cycle request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_region | input | $clog2(REGIONS) | Region of the access |
| req_burst | input | 1 | 1 = burst of BEATS beats |
| opt_wait | input | WS_W | First-access wait states |
| opt_bwait | input | WS_W | Burst-beat wait states |
| opt_csd | input | 2 | Chip-select delay code |
| opt_relax | input | 1 | Relaxed timing mode |
| opt_ext | input | 1 | External termination select |
| opt_hold | input | 1 | Idle clock after reads |
| opt_bi_late | input | 1 | Late rise of burst indicator |
| opt_bi_trim | input | 1 | Early fall of burst indicator |
| ta_in | input | 1 | External transfer acknowledge |
| cs_o | output | 1 | Chip select |
| oe_o | output | 1 | Output enable (reads) |
| we_o | output | 1 | Write / byte enable (writes) |
| burst_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-clock cycle-done pulse |
| cfg_err_o | output | 1 | Sticky configuration error |

## Verification
Two events can land on the same clock: the end of a beat, and a stalled quarter (`qtick` low) or a change of `ta_in`. The final quarter of a beat can also coincide with a new request arriving while the block is still busy. The bench drops `qtick` at random inside cycles and gaps, toggles `ta_in` on internally terminated cycles, and keeps a conflicting request asserted for a whole cycle. Every quarter it compares the strobes and `done_o` against a model indexed by the number of ticks since the request was taken. A stall or request that leaked into the timing shows up as a shifted strobe edge or a misplaced done pulse.

// File: rtl/css_pkg.sv
// Shared types and constants of the chip-select strobe sequencer.
// Assumes: quarter counts are measured in ticks of the 4x clock.
package css_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_GAP  = 2'd1,
        ST_ACT  = 2'd2
    } seq_state_e;

    localparam logic [1:0] CSD_WITH_ADDR = 2'b00;
    localparam logic [1:0] CSD_RESERVED  = 2'b01;
    localparam logic [1:0] CSD_QUARTER   = 2'b10;
    localparam logic [1:0] CSD_HALF      = 2'b11;

    localparam int RELAX_SHIFT_Q = 4;  // relaxed mode pushes edges by one bus clock
    localparam int STROBE_BASE_Q = 3;  // OE / WE rise three quarters after start
endpackage

// File: rtl/css_cfg_decode.sv
// Turns the raw option fields of a request into beat lengths, edge positions
// and burst-indicator beat range. Purely combinational; the top latches it.
// Assumes BEATS >= 4 so that the trimmed range is non-empty.
module css_cfg_decode
    import css_pkg::*;
#(
    parameter int WS_W   = 4,
    parameter int BEATS  = 4,
    parameter int LEN_W  = WS_W + 3,
    parameter int BEAT_W = $clog2(BEATS),
    parameter int QE_W   = 4
) (
    input  logic [WS_W-1:0]   wait_cnt,
    input  logic [WS_W-1:0]   bwait_cnt,
    input  logic [1:0]        csd_code,
    input  logic              relax,
    input  logic              ext,
    input  logic              bi_late,
    input  logic              bi_trim,
    input  logic              burst,
    output logic [LEN_W-1:0]  len_first,
    output logic [LEN_W-1:0]  len_burst,
    output logic [LEN_W-1:0]  min_first,
    output logic [QE_W-1:0]   csd_q,
    output logic [QE_W-1:0]   strobe_q,
    output logic [BEAT_W-1:0] last_beat,
    output logic [BEAT_W-1:0] bi_lo,
    output logic [BEAT_W-1:0] bi_hi,
    output logic              cfg_bad
);
    logic [LEN_W-1:0] w_first;
    logic [LEN_W-1:0] w_burst;
    logic             both_bi;
    logic             bi_opts_ok;

    // Wait states, doubled in relaxed mode, and the resulting beat lengths.
    always_comb begin
        w_first   = relax ? (LEN_W'(wait_cnt) << 1)  : LEN_W'(wait_cnt);
        w_burst   = relax ? (LEN_W'(bwait_cnt) << 1) : LEN_W'(bwait_cnt);
        min_first = LEN_W'(2) + LEN_W'(relax);
        len_first = min_first + w_first;
        len_burst = LEN_W'(1) + w_burst;
    end

    // Chip-select delay and strobe position in quarters; reserved code acts as 00.
    always_comb begin
        case (csd_code)
            CSD_QUARTER: csd_q = QE_W'(1);
            CSD_HALF:    csd_q = QE_W'(2);
            default:     csd_q = '0;
        endcase
        if (relax && (csd_q != '0)) csd_q = csd_q + QE_W'(RELAX_SHIFT_Q);
        strobe_q = QE_W'(STROBE_BASE_Q) + (relax ? QE_W'(RELAX_SHIFT_Q) : '0);
    end

    // Burst-indicator beat range and configuration error detection.
    always_comb begin
        both_bi    = bi_late && bi_trim;
        bi_opts_ok = !both_bi && !ext;
        last_beat  = burst ? BEAT_W'(BEATS - 1) : '0;
        bi_lo      = (bi_opts_ok && bi_late) ? BEAT_W'(1) : '0;
        bi_hi      = (bi_opts_ok && bi_trim) ? BEAT_W'(BEATS - 3) : BEAT_W'(BEATS - 2);
        cfg_bad    = (csd_code == CSD_RESERVED) || both_bi;
    end
endmodule

// File: rtl/css_beat_timer.sv
// Counts quarters, bus clocks and beats of an active cycle and flags the
// quarter on which the cycle ends. Counters clear on start and move only on ticks.
// Assumes len_first >= min_first >= 1 and len_burst >= 1.
module css_beat_timer #(
    parameter int LEN_W  = 7,
    parameter int BEAT_W = 2,
    parameter int QE_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic              run,
    input  logic              ext,
    input  logic              ta,
    input  logic [LEN_W-1:0]  len_first,
    input  logic [LEN_W-1:0]  len_burst,
    input  logic [LEN_W-1:0]  min_first,
    input  logic [BEAT_W-1:0] last_beat,
    output logic [QE_W-1:0]   qcount,
    output logic [BEAT_W-1:0] beat,
    output logic              cycle_end
);
    logic [1:0]       phase;
    logic [LEN_W-1:0] clk_cnt;
    logic [LEN_W-1:0] beat_len;
    logic [LEN_W-1:0] beat_min;
    logic             clock_end;
    logic             beat_done;

    // End-of-beat decision: internal count or acknowledge after the minimum.
    always_comb begin
        beat_len  = (beat == '0) ? len_first : len_burst;
        beat_min  = (beat == '0) ? min_first : LEN_W'(1);
        clock_end = run && tick && (phase == 2'd3);
        beat_done = ext ? (ta && (clk_cnt >= beat_min - LEN_W'(1)))
                        : (clk_cnt == beat_len - LEN_W'(1));
        cycle_end = clock_end && beat_done && (beat == last_beat);
    end

    // Phase, clock-in-beat, beat and saturating quarter counters.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            phase   <= '0;
            clk_cnt <= '0;
            beat    <= '0;
            qcount  <= '0;
        end else if (run && tick) begin
            phase <= phase + 2'd1;
            if (qcount != '1) qcount <= qcount + QE_W'(1);
            if (phase == 2'd3) begin
                if (beat_done) begin
                    clk_cnt <= '0;
                    if (beat != last_beat) beat <= beat + BEAT_W'(1);
                end else if (clk_cnt != '1) begin
                    clk_cnt <= clk_cnt + LEN_W'(1);
                end
            end
        end
    end

    AST_BEAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (beat <= last_beat)); // R6
    AST_INT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ext) |-> (clk_cnt < beat_len)); // R2
endmodule

// File: rtl/css_strobe_gen.sv
// Decodes the strobes from the quarter count and the beat number of the
// active cycle. Combinational; all outputs are low outside an active cycle.
module css_strobe_gen #(
    parameter int BEAT_W = 2,
    parameter int QE_W   = 4
) (
    input  logic              act,
    input  logic              write,
    input  logic              burst,
    input  logic [QE_W-1:0]   qcount,
    input  logic [BEAT_W-1:0] beat,
    input  logic [QE_W-1:0]   csd_q,
    input  logic [QE_W-1:0]   strobe_q,
    input  logic [BEAT_W-1:0] bi_lo,
    input  logic [BEAT_W-1:0] bi_hi,
    output logic              cs,
    output logic              oe,
    output logic              we,
    output logic              bi
);
    logic strobe_on;

    // Edge positions compared against the elapsed quarters.
    always_comb begin
        strobe_on = act && (qcount >= strobe_q);
        cs        = act && (qcount >= csd_q);
        oe        = strobe_on && !write;
        we        = strobe_on && write;
        bi        = act && burst && (beat >= bi_lo) && (beat <= bi_hi);
    end
endmodule

// File: rtl/cs_strobe_seq.sv
// Chip-select strobe sequencer top. Accepts one request at a time while idle,
// optionally inserts an idle bus clock after reads, then runs the cycle.
// Assumes clk is the 4x clock and qtick marks the quarters to count.
module cs_strobe_seq
    import css_pkg::*;
#(
    parameter int REGIONS = 8,
    parameter int WS_W    = 4,
    parameter int BEATS   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       qtick,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [$clog2(REGIONS)-1:0] req_region,
    input  logic                       req_burst,
    input  logic [WS_W-1:0]            opt_wait,
    input  logic [WS_W-1:0]            opt_bwait,
    input  logic [1:0]                 opt_csd,
    input  logic                       opt_relax,
    input  logic                       opt_ext,
    input  logic                       opt_hold,
    input  logic                       opt_bi_late,
    input  logic                       opt_bi_trim,
    input  logic                       ta_in,
    output logic                       cs_o,
    output logic                       oe_o,
    output logic                       we_o,
    output logic                       burst_o,
    output logic                       done_o,
    output logic                       cfg_err_o
);
    localparam int RGN_W  = $clog2(REGIONS);
    localparam int LEN_W  = WS_W + 3;
    localparam int BEAT_W = $clog2(BEATS);
    localparam int QE_W   = 4;

    seq_state_e        st;
    logic [1:0]        gap_cnt;
    logic              accept, need_gap, start, cycle_end;
    logic [LEN_W-1:0]  d_len_first, d_len_burst, d_min_first;
    logic [QE_W-1:0]   d_csd_q, d_strobe_q;
    logic [BEAT_W-1:0] d_last_beat, d_bi_lo, d_bi_hi;
    logic              d_bad;
    logic [LEN_W-1:0]  l_len_first, l_len_burst, l_min_first;
    logic [QE_W-1:0]   l_csd_q, l_strobe_q;
    logic [BEAT_W-1:0] l_last_beat, l_bi_lo, l_bi_hi;
    logic              l_write, l_burst, l_ext;
    logic              prev_v, prev_rd, prev_hold;
    logic [RGN_W-1:0]  prev_rgn;
    logic [QE_W-1:0]   qcount;
    logic [BEAT_W-1:0] beat;

    css_cfg_decode #(.WS_W(WS_W), .BEATS(BEATS), .LEN_W(LEN_W),
                     .BEAT_W(BEAT_W), .QE_W(QE_W)) u_decode (
        .wait_cnt(opt_wait), .bwait_cnt(opt_bwait), .csd_code(opt_csd),
        .relax(opt_relax), .ext(opt_ext), .bi_late(opt_bi_late),
        .bi_trim(opt_bi_trim), .burst(req_burst),
        .len_first(d_len_first), .len_burst(d_len_burst), .min_first(d_min_first),
        .csd_q(d_csd_q), .strobe_q(d_strobe_q), .last_beat(d_last_beat),
        .bi_lo(d_bi_lo), .bi_hi(d_bi_hi), .cfg_bad(d_bad)
    );

    // Request acceptance, idle-gap decision and cycle start.
    always_comb begin
        accept   = (st == ST_IDLE) && qtick && req_valid;
        need_gap = prev_v && prev_rd && prev_hold &&
                   (req_write || (req_region != prev_rgn));
        start    = (accept && !need_gap) ||
                   ((st == ST_GAP) && qtick && (gap_cnt == 2'd3));
    end

    // Sequencer state: idle, idle-gap of four ticks, active cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            gap_cnt <= '0;
        end else begin
            case (st)
                ST_IDLE: if (accept) begin
                    st      <= need_gap ? ST_GAP : ST_ACT;
                    gap_cnt <= '0;
                end
                ST_GAP: if (qtick) begin
                    gap_cnt <= gap_cnt + 2'd1;
                    if (gap_cnt == 2'd3) st <= ST_ACT;
                end
                ST_ACT: if (cycle_end) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Latch decoded timing of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {l_write, l_burst, l_ext} <= '0;
            l_len_first <= '0; l_len_burst <= '0; l_min_first <= '0;
            l_csd_q <= '0; l_strobe_q <= '0;
            l_last_beat <= '0; l_bi_lo <= '0; l_bi_hi <= '0;
        end else if (accept) begin
            l_write     <= req_write;
            l_burst     <= req_burst;
            l_ext       <= opt_ext;
            l_len_first <= d_len_first;
            l_len_burst <= d_len_burst;
            l_min_first <= d_min_first;
            l_csd_q     <= d_csd_q;
            l_strobe_q  <= d_strobe_q;
            l_last_beat <= d_last_beat;
            l_bi_lo     <= d_bi_lo;
            l_bi_hi     <= d_bi_hi;
        end
    end

    // Remember direction, region and hold option of the last access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_v <= 1'b0; prev_rd <= 1'b0; prev_hold <= 1'b0; prev_rgn <= '0;
        end else if (accept) begin
            prev_v    <= 1'b1;
            prev_rd   <= !req_write;
            prev_hold <= opt_hold;
            prev_rgn  <= req_region;
        end
    end

    // Sticky configuration error and one-clock done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_err_o <= 1'b0;
            done_o    <= 1'b0;
        end else begin
            if (accept && d_bad) cfg_err_o <= 1'b1;
            done_o <= cycle_end;
        end
    end

    css_beat_timer #(.LEN_W(LEN_W), .BEAT_W(BEAT_W), .QE_W(QE_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(qtick), .start(start),
        .run(st == ST_ACT), .ext(l_ext), .ta(ta_in),
        .len_first(l_len_first), .len_burst(l_len_burst), .min_first(l_min_first),
        .last_beat(l_last_beat), .qcount(qcount), .beat(beat), .cycle_end(cycle_end)
    );

    css_strobe_gen #(.BEAT_W(BEAT_W), .QE_W(QE_W)) u_strobe (
        .act(st == ST_ACT), .write(l_write), .burst(l_burst), .qcount(qcount),
        .beat(beat), .csd_q(l_csd_q), .strobe_q(l_strobe_q),
        .bi_lo(l_bi_lo), .bi_hi(l_bi_hi),
        .cs(cs_o), .oe(oe_o), .we(we_o), .bi(burst_o)
    );

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(oe_o && we_o)); // R5
    AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_o || we_o) |-> cs_o); // R4
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !(cs_o || oe_o || we_o || burst_o)); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R2
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |=> cfg_err_o); // R8
    AST_GAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_GAP) |-> !(cs_o || oe_o || we_o || burst_o)); // R7
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!qtick && st == ST_ACT) |=> $stable({cs_o, oe_o, we_o, burst_o})); // R9
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACT && !cycle_end) |=> (st == ST_ACT || st == ST_IDLE)); // R10
endmodule

// File: tb/cs_strobe_seq_tb.sv
module cs_strobe_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       qtick = 1'b0, req_valid = 1'b0, req_write = 1'b0, req_burst = 1'b0;
    logic [2:0] req_region = '0;
    logic [3:0] opt_wait = '0, opt_bwait = '0;
    logic [1:0] opt_csd = '0;
    logic       opt_relax = 0, opt_ext = 0, opt_hold = 0, opt_bi_late = 0, opt_bi_trim = 0;
    logic       ta_in = 0;
    logic       cs_o, oe_o, we_o, burst_o, done_o, cfg_err_o;

    int n_tests = 0, n_fail = 0;
    bit finished = 0;
    bit pv = 0, prd = 0, peh = 0, err_exp = 0;
    int preg = 0;

    always #10 clk = ~clk;  // 50 MHz

    cs_strobe_seq u_dut (
        .clk(clk), .rst_n(rst_n), .qtick(qtick), .req_valid(req_valid),
        .req_write(req_write), .req_region(req_region), .req_burst(req_burst),
        .opt_wait(opt_wait), .opt_bwait(opt_bwait), .opt_csd(opt_csd),
        .opt_relax(opt_relax), .opt_ext(opt_ext), .opt_hold(opt_hold),
        .opt_bi_late(opt_bi_late), .opt_bi_trim(opt_bi_trim), .ta_in(ta_in),
        .cs_o(cs_o), .oe_o(oe_o), .we_o(we_o), .burst_o(burst_o),
        .done_o(done_o), .cfg_err_o(cfg_err_o)
    );

    task automatic chk(input string tag, input string what, input logic got, input logic exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %b expected %b", tag, what, got, exp);
        end
    endtask

    function automatic int cs_delay(input int acs, input bit relax);
        int d;
        d = (acs == 2) ? 1 : (acs == 3) ? 2 : 0;  // reserved 01 acts as 00 (R8)
        if (d != 0 && relax) d += 4;
        return d;
    endfunction

    // First ext-terminated beat: clock index at which TA (high from quarter tf) ends it.
    function automatic int ext_first_clocks(input bit relax, input int tf);
        int c;
        c = 1 + int'(relax);
        while (4 * c + 3 < tf) c++;
        return c + 1;
    endfunction

    task automatic run_cycle(input bit wr, input int rgn, input bit burst,
                             input int scy, input int bscy, input int acs,
                             input bit relax, input bit ext, input bit hold,
                             input bit late, input bit trim, input int tf,
                             input int pq, input bit poke, input string tag);
        int csd, stq, nb, q1, qb, qtot, lo, hi, off, t, q, bt, guard;
        bit gap, act;
        csd = cs_delay(acs, relax);
        stq = relax ? 7 : 3;
        nb  = burst ? 4 : 1;
        if (ext) begin
            q1 = 4 * ext_first_clocks(relax, tf);
            qb = 4;
        end else begin
            q1 = 4 * (2 + int'(relax) + (relax ? 2 * scy : scy));
            qb = 4 * (1 + (relax ? 2 * bscy : bscy));
        end
        qtot = q1 + (nb - 1) * qb;
        if (ext || (late && trim)) begin lo = 0; hi = nb - 2; end
        else begin lo = late ? 1 : 0; hi = trim ? nb - 3 : nb - 2; end
        gap = pv && prd && peh && (wr || rgn != preg);
        off = gap ? 4 : 0;
        pv = 1; prd = !wr; peh = hold; preg = rgn;
        if (acs == 1 || (late && trim)) err_exp = 1;

        @(negedge clk);
        req_valid = 1; req_write = wr; req_region = 3'(rgn); req_burst = burst;
        opt_wait = 4'(scy); opt_bwait = 4'(bscy); opt_csd = 2'(acs);
        opt_relax = relax; opt_ext = ext; opt_hold = hold;
        opt_bi_late = late; opt_bi_trim = trim; qtick = 1; ta_in = 0;
        @(posedge clk);
        t = 0; guard = 0;
        forever begin
            @(negedge clk);
            if (poke) begin  // R10: conflicting request held during the cycle
                req_valid = 1; req_write = !wr; req_region = 3'(rgn + 1);
                opt_csd = 2'b11; opt_relax = !relax;
            end else req_valid = 0;
            q = t - off;
            act = (q >= 0) && (q < qtot);
            bt = (q < q1) ? 0 : 1 + (q - q1) / qb;
            chk({tag, " R4"}, "cs_o", cs_o, act && q >= csd);
            chk({tag, " R5"}, "oe_o", oe_o, act && !wr && q >= stq);
            chk({tag, " R5"}, "we_o", we_o, act && wr && q >= stq);
            chk({tag, " R6"}, "burst_o", burst_o, act && burst && bt >= lo && bt <= hi);
            chk({tag, ext ? " R3" : " R2"}, "done_o", done_o, q == qtot);
            if (q == qtot) begin
                req_valid = 0;
                chk({tag, " R8"}, "cfg_err_o", cfg_err_o, err_exp);
                break;
            end
            guard++;
            if (guard > 4000) begin
                n_fail++; $display("FAIL %s R2: cycle never ended, got q=%0d expected %0d", tag, q, qtot);
                break;
            end
            qtick = ($urandom % 100) < pq;  // R9: stalled quarters
            ta_in = ext ? (q >= tf) : 1'($urandom);  // R2: ignored when internal
            if (qtick) t++;
        end
        qtick = 1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", "cs_o", cs_o, 0);   chk("R1", "oe_o", oe_o, 0);
        chk("R1", "we_o", we_o, 0);   chk("R1", "burst_o", burst_o, 0);
        chk("R1", "done_o", done_o, 0); chk("R1", "cfg_err_o", cfg_err_o, 0);
        rst_n = 1;
        @(negedge clk);
        // Directed corners
        run_cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 100, 0, "R2 plain read");
        run_cycle(1, 1, 0, 3, 0, 2, 0, 0, 0, 0, 0, 0, 100, 0, "R4 write csd10");
        run_cycle(0, 1, 0, 15, 0, 3, 1, 0, 0, 0, 0, 0, 100, 0, "R2 relax max wait");
        run_cycle(1, 2, 0, 0, 0, 3, 1, 1, 0, 0, 0, 0, 100, 0, "R3 relax ext min");
        run_cycle(0, 2, 0, 5, 0, 0, 0, 1, 0, 0, 0, 0, 100, 0, "R3 ext min2");
        run_cycle(1, 2, 1, 2, 1, 0, 0, 1, 0, 0, 0, 21, 100, 0, "R3 ext late ta");
        run_cycle(0, 3, 1, 1, 2, 2, 0, 0, 0, 0, 0, 0, 100, 0, "R6 burst normal");
        run_cycle(0, 3, 1, 1, 2, 2, 1, 0, 0, 1, 0, 0, 100, 0, "R6 burst late");
        run_cycle(1, 3, 1, 0, 0, 0, 0, 0, 0, 0, 1, 0, 100, 0, "R6 burst trim");
        run_cycle(1, 3, 1, 0, 1, 0, 0, 1, 0, 1, 0, 0, 100, 0, "R6 late ignored ext");
        // R7 idle gap sequence
        run_cycle(0, 1, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 100, 0, "R7 read hold");
        run_cycle(0, 1, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 100, 0, "R7 same rgn read");
        run_cycle(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 100, 0, "R7 write after read");
        run_cycle(0, 4, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 100, 0, "R7 read no hold prev");
        run_cycle(0, 5, 0, 1, 0, 3, 0, 0, 0, 0, 0, 0, 60, 0, "R7 other rgn gap");
        // R9 stalls and R10 busy requests
        run_cycle(1, 6, 1, 2, 1, 3, 1, 0, 0, 0, 0, 0, 50, 0, "R9 stalled burst");
        run_cycle(0, 6, 1, 1, 1, 2, 0, 0, 0, 0, 0, 0, 80, 1, "R10 busy request");
        // R8 configuration errors
        run_cycle(0, 7, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 100, 0, "R8 reserved csd");
        run_cycle(1, 7, 1, 0, 0, 0, 0, 0, 0, 1, 1, 0, 100, 0, "R8 both bi opts");
        // Constrained random mix
        for (int i = 0; i < 150; i++) begin
            run_cycle(1'($urandom), int'($urandom % 8), 1'($urandom),
                      int'($urandom % 8), int'($urandom % 8), int'($urandom % 4),
                      1'($urandom), ($urandom % 3) == 0, 1'($urandom),
                      ($urandom % 3) == 0, ($urandom % 3) == 0, int'($urandom % 40),
                      60 + int'($urandom % 41), ($urandom % 8) == 0, "rand");
            repeat ($urandom % 3) @(negedge clk);
        end
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule